// File: doc/BRIEF.md
# PLL Coefficient Reprogramming Sequencer

This block steps an on-chip PLL from one set of divider settings (input divider M, feedback divider N, post divider PL) to another so that the clock it drives never glitches. It drives the PLL's control pins: the output select between VCO and bypass, a halving output divider, the power-down (IDDQ) control, enable, lock-detect enable, slowdown mode, dynamic-ramp enable, the ramp step values and the three coefficients. It watches the PLL's lock and ramp-done flags. All waits are counted in microseconds from an internal prescaler of `TICK_DIV` clock cycles per microsecond.

A program request picks one of two paths. It uses an N-only ramp when slide mode is requested, the PLL is running, and M and PL do not change. Otherwise it does a full relock. The relock first ramps N down to the minimum-VCO value for the current M. It then halves the output and switches to bypass, reprograms and relocks, switches back to the VCO, restores the divider and ramps N up to the target. If a ramp in slide mode times out, the whole program is rerun without slide. A disable request ramps N down, selects bypass and turns the PLL off. The caller supplies the target N and both minimum-VCO N values.

Top module: `pll_reseq`

## Requirements
- R1: After reset, busy and done are 0, iddq is 1, pll_en is 0, sel_vco is 0 (0 = bypass, 1 = VCO), half_div is 0, and slowdown and dynramp_en are 0.
- R2: A program request with slide_en=1, while pll_en=1 and new_m/new_pl equal coef_m/coef_pl, only ramps N to tgt_n. pll_en never rises and the final coef_n is tgt_n.
- R3: A ramp whose target equals coef_n does nothing. Otherwise it loads step_a=0x2B and step_b=0x0B and raises slowdown. It writes coef_n exactly TICK_DIV cycles later and raises dynramp_en TICK_DIV cycles after that.
- R4: ramp_done is polled once per microsecond for up to RAMP_POLLS polls. When done is seen, or the polls run out, slowdown and dynramp_en fall in the same cycle. With no done, dynramp_en stays high exactly RAMP_POLLS*TICK_DIV cycles.
- R5: A full relock with slide mode and a running PLL first ramps N to nlo_cur. It then raises half_div and drops sel_vco 2*TICK_DIV cycles later.
- R6: If iddq is set, the relock clears it and waits 2 µs. It then clears pll_en and writes coef_m=new_m and coef_pl=new_pl, with coef_n=nlo_new in slide mode or tgt_n otherwise. Finally it raises pll_en and lckdet_en. Coefficients only change while pll_en is 0.
- R7: pll_lock is polled every 2 µs, up to LOCK_POLLS = LOCK_US/2+1 polls. If lock never comes, done is raised together with fail exactly 2*LOCK_POLLS*TICK_DIV cycles after pll_en rises, and sel_vco is left at 0.
- R8: After lock, sel_vco rises while half_div is 1. half_div falls 2*TICK_DIV cycles later, and N is then ramped to tgt_n.
- R9: A ramp timeout during a slide-mode program reruns the program with slide off. The rerun relocks with coef_n=tgt_n and ends without fail.
- R10: A disable request (req_off) ramps N to nlo_cur if pll_en is 1, then drops sel_vco, then clears pll_en. It never reports fail.
- R11: busy is high from the cycle after an accepted request until done. done lasts one cycle. Requests that arrive while busy are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_on | input | 1 | Program request pulse |
| req_off | input | 1 | Disable request pulse |
| slide_en | input | 1 | Allow N ramps for this program |
| new_m | input | MW | Requested input divider |
| new_pl | input | PW | Requested post divider |
| tgt_n | input | NW | Requested feedback divider |
| nlo_new | input | NW | Minimum-VCO N for new_m |
| nlo_cur | input | NW | Minimum-VCO N for the current M |
| pll_lock | input | 1 | PLL lock flag |
| ramp_done | input | 1 | PLL dynamic ramp finished |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| fail | output | 1 | Lock failure, valid with done |
| coef_m | output | MW | Input divider coefficient |
| coef_n | output | NW | Feedback divider coefficient |
| coef_pl | output | PW | Post divider coefficient |
| step_a | output | 8 | Ramp step value A |
| step_b | output | 8 | Ramp step value B |
| sel_vco | output | 1 | Output select, 1 = VCO, 0 = bypass |
| half_div | output | 1 | Output divider 1:2 when 1 |
| iddq | output | 1 | PLL power-down |
| pll_en | output | 1 | PLL enable |
| lckdet_en | output | 1 | Lock detector enable |
| slowdown | output | 1 | Slowdown mode |
| dynramp_en | output | 1 | Dynamic ramp enable |

## Verification
Some internal faults show up as an ordering error on the control pins, and these show within a cycle. Examples are switching to the VCO with the divider at 1:1, changing a coefficient while the PLL is enabled, or raising dynamic ramp outside slowdown mode. A wrong wait or poll count moves an edge by a whole number of microseconds, so the bench measures the distance between edges exactly. A wrong path choice, such as a relock where an N-only ramp was due, a missing retry, or a wrong N written before lock, shows as an extra or missing pll_en rise or slowdown pulse, or as a wrong final coefficient when done arrives.

// File: rtl/pll_reseq.sv
module pll_reseq #(
  parameter int MW = 8,
  parameter int NW = 8,
  parameter int PW = 6,
  parameter int TICK_DIV = 100,
  parameter int RAMP_POLLS = 500,
  parameter int LOCK_US = 300,
  parameter logic [7:0] STEP_A = 8'h2B,
  parameter logic [7:0] STEP_B = 8'h0B
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_on,
  input  logic          req_off,
  input  logic          slide_en,
  input  logic [MW-1:0] new_m,
  input  logic [PW-1:0] new_pl,
  input  logic [NW-1:0] tgt_n,
  input  logic [NW-1:0] nlo_new,
  input  logic [NW-1:0] nlo_cur,
  input  logic          pll_lock,
  input  logic          ramp_done,
  output logic          busy,
  output logic          done,
  output logic          fail,
  output logic [MW-1:0] coef_m,
  output logic [NW-1:0] coef_n,
  output logic [PW-1:0] coef_pl,
  output logic [7:0]    step_a,
  output logic [7:0]    step_b,
  output logic          sel_vco,
  output logic          half_div,
  output logic          iddq,
  output logic          pll_en,
  output logic          lckdet_en,
  output logic          slowdown,
  output logic          dynramp_en
);
  localparam int LOCK_POLLS = LOCK_US / 2 + 1;
  localparam int PMAX = (RAMP_POLLS > LOCK_POLLS) ? RAMP_POLLS : LOCK_POLLS;
  localparam int CW = $clog2(PMAX + 1);
  localparam int TW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [TW-1:0] TICK_LAST = TW'(TICK_DIV - 1);
  localparam logic [CW-1:0] RAMP_LAST = CW'(RAMP_POLLS - 1);
  localparam logic [CW-1:0] LOCK_LAST = CW'(LOCK_POLLS - 1);

  typedef enum logic [4:0] {
    S_IDLE, S_START, S_RSET, S_RW1, S_RW2, S_RPOLL, S_RFAIL,
    S_HALF, S_BYP, S_PWR, S_PWRW, S_OFF, S_COEF, S_ON, S_LOCK,
    S_VCO, S_FULL, S_DSTART, S_DBYP, S_DOFF, S_FIN
  } st_t;

  st_t st, ret;
  logic [TW-1:0] cyc;
  logic [CW-1:0] pcnt;
  logic          half, slide, dis_mode, err;
  logic [MW-1:0] m_r;
  logic [PW-1:0] pl_r;
  logic [NW-1:0] n_r, nlon_r, nloc_r, ramp_n;

  wire tick = (cyc == TICK_LAST);

  assign busy = (st != S_IDLE);
  assign done = (st == S_FIN);
  assign fail = done & err;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; ret <= S_IDLE;
      cyc <= '0; pcnt <= '0; half <= 1'b0;
      slide <= 1'b0; dis_mode <= 1'b0; err <= 1'b0;
      m_r <= '0; pl_r <= '0; n_r <= '0; nlon_r <= '0; nloc_r <= '0; ramp_n <= '0;
      coef_m <= MW'(1); coef_pl <= PW'(1); coef_n <= '0;
      step_a <= '0; step_b <= '0;
      sel_vco <= 1'b0; half_div <= 1'b0; iddq <= 1'b1; pll_en <= 1'b0;
      lckdet_en <= 1'b0; slowdown <= 1'b0; dynramp_en <= 1'b0;
    end else begin
      cyc <= tick ? '0 : cyc + 1'b1;
      case (st)
        S_IDLE: begin
          cyc <= '0;
          if (req_on || req_off) begin
            m_r <= new_m; pl_r <= new_pl; n_r <= tgt_n;
            nlon_r <= nlo_new; nloc_r <= nlo_cur;
            slide <= slide_en; err <= 1'b0;
            dis_mode <= !req_on;
            st <= req_on ? S_START : S_DSTART;
          end
        end
        S_START: begin
          cyc <= '0; pcnt <= '0;
          if (slide && pll_en && m_r == coef_m && pl_r == coef_pl) begin
            ramp_n <= n_r; ret <= S_FIN; st <= S_RSET;
          end else if (slide && pll_en) begin
            ramp_n <= nloc_r; ret <= S_HALF; st <= S_RSET;
          end else st <= S_HALF;
        end
        S_RSET: begin
          cyc <= '0; pcnt <= '0;
          if (ramp_n == coef_n) st <= ret;
          else begin
            step_a <= STEP_A; step_b <= STEP_B; slowdown <= 1'b1; st <= S_RW1;
          end
        end
        S_RW1: if (tick) begin coef_n <= ramp_n; st <= S_RW2; end
        S_RW2: if (tick) begin dynramp_en <= 1'b1; st <= S_RPOLL; end
        S_RPOLL: if (tick) begin
          if (ramp_done || pcnt == RAMP_LAST) begin
            slowdown <= 1'b0; dynramp_en <= 1'b0; pcnt <= '0;
            st <= (ramp_done || dis_mode) ? ret : S_RFAIL;
          end else pcnt <= pcnt + 1'b1;
        end
        S_RFAIL: begin
          cyc <= '0;
          if (slide) begin slide <= 1'b0; st <= S_START; end
          else begin err <= 1'b1; st <= S_FIN; end
        end
        S_HALF: begin
          half_div <= 1'b1; cyc <= '0; pcnt <= '0; st <= S_BYP;
        end
        S_BYP: if (tick) begin
          if (pcnt == CW'(1)) begin sel_vco <= 1'b0; pcnt <= '0; st <= S_PWR; end
          else pcnt <= pcnt + 1'b1;
        end
        S_PWR: begin
          cyc <= '0; pcnt <= '0;
          if (iddq) begin iddq <= 1'b0; st <= S_PWRW; end
          else st <= S_OFF;
        end
        S_PWRW: if (tick) begin
          if (pcnt == CW'(1)) begin pcnt <= '0; st <= S_OFF; end
          else pcnt <= pcnt + 1'b1;
        end
        S_OFF: begin cyc <= '0; pll_en <= 1'b0; st <= S_COEF; end
        S_COEF: begin
          cyc <= '0;
          coef_m <= m_r; coef_pl <= pl_r;
          coef_n <= slide ? nlon_r : n_r;
          st <= S_ON;
        end
        S_ON: begin
          cyc <= '0; pcnt <= '0; half <= 1'b0;
          pll_en <= 1'b1; lckdet_en <= 1'b1; st <= S_LOCK;
        end
        S_LOCK: if (tick) begin
          if (!half) half <= 1'b1;
          else begin
            half <= 1'b0;
            if (pll_lock) begin pcnt <= '0; st <= S_VCO; end
            else if (pcnt == LOCK_LAST) begin err <= 1'b1; st <= S_FIN; end
            else pcnt <= pcnt + 1'b1;
          end
        end
        S_VCO: begin
          cyc <= '0; pcnt <= '0; sel_vco <= 1'b1; st <= S_FULL;
        end
        S_FULL: if (tick) begin
          if (pcnt == CW'(1)) begin
            half_div <= 1'b0; ramp_n <= n_r; ret <= S_FIN; pcnt <= '0; st <= S_RSET;
          end else pcnt <= pcnt + 1'b1;
        end
        S_DSTART: begin
          cyc <= '0;
          if (pll_en) begin ramp_n <= nloc_r; ret <= S_DBYP; st <= S_RSET; end
          else st <= S_DBYP;
        end
        S_DBYP: begin cyc <= '0; sel_vco <= 1'b0; st <= S_DOFF; end
        S_DOFF: begin cyc <= '0; pll_en <= 1'b0; st <= S_FIN; end
        S_FIN: begin cyc <= '0; st <= S_IDLE; end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pll_reseq_chk.sv
module pll_reseq_chk #(
  parameter int MW = 8,
  parameter int NW = 8,
  parameter int PW = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          done,
  input logic          sel_vco,
  input logic          half_div,
  input logic          pll_en,
  input logic          slowdown,
  input logic          dynramp_en,
  input logic [MW-1:0] coef_m,
  input logic [NW-1:0] coef_n,
  input logic [PW-1:0] coef_pl
);
  a_r3_ramp_inside_slowdown: assert property (@(posedge clk) disable iff (!rst_n)
    dynramp_en |-> slowdown);

  a_r3_n_moves_in_slowdown: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(coef_n) && pll_en) |-> slowdown);

  a_r6_coef_while_off: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(coef_m) || !$stable(coef_pl)) |-> !pll_en);

  a_r5_enable_in_bypass: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pll_en) |-> !sel_vco);

  a_r8_vco_with_half: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sel_vco) |-> half_div);

  a_r11_done_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> busy);

  a_r11_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

bind pll_reseq pll_reseq_chk #(.MW(MW), .NW(NW), .PW(PW)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .sel_vco(sel_vco),
  .half_div(half_div), .pll_en(pll_en), .slowdown(slowdown),
  .dynramp_en(dynramp_en), .coef_m(coef_m), .coef_n(coef_n), .coef_pl(coef_pl)
);

// File: tb/pll_reseq_test.sv
`timescale 1ns/1ps
module pll_reseq_test;
  localparam int T = 4;
  localparam int RP = 500;
  localparam int LP = 151;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_on = 1'b0, req_off = 1'b0, slide_en = 1'b0;
  logic [7:0] new_m = '0, tgt_n = '0, nlo_new = '0, nlo_cur = '0;
  logic [5:0] new_pl = '0;
  logic pll_lock, ramp_done;
  logic busy, done, fail, sel_vco, half_div, iddq, pll_en, lckdet_en, slowdown, dynramp_en;
  logic [7:0] coef_m, coef_n, step_a, step_b;
  logic [5:0] coef_pl;

  always #2.5 clk = ~clk;

  pll_reseq #(.TICK_DIV(T), .RAMP_POLLS(RP), .LOCK_US(300)) uut (
    .clk(clk), .rst_n(rst_n), .req_on(req_on), .req_off(req_off), .slide_en(slide_en),
    .new_m(new_m), .new_pl(new_pl), .tgt_n(tgt_n), .nlo_new(nlo_new), .nlo_cur(nlo_cur),
    .pll_lock(pll_lock), .ramp_done(ramp_done), .busy(busy), .done(done), .fail(fail),
    .coef_m(coef_m), .coef_n(coef_n), .coef_pl(coef_pl), .step_a(step_a), .step_b(step_b),
    .sel_vco(sel_vco), .half_div(half_div), .iddq(iddq), .pll_en(pll_en),
    .lckdet_en(lckdet_en), .slowdown(slowdown), .dynramp_en(dynramp_en));

  // analog PLL model
  logic lock_hang = 1'b0, ramp_hang = 1'b0;
  int lk_cnt = 0, rd_cnt = 0, cyc_no = 0;
  always @(posedge clk) begin
    cyc_no <= cyc_no + 1;
    lk_cnt <= pll_en ? lk_cnt + 1 : 0;
    rd_cnt <= dynramp_en ? rd_cnt + 1 : 0;
  end
  assign pll_lock = (lk_cnt >= 20) && !lock_hang;
  assign ramp_done = (rd_cnt >= 5) && !ramp_hang;

  // edge monitor
  logic mon_clr = 1'b0;
  int n_en, n_ramp, n_done, t_enr, t_enf, t_sd, t_sd1, t_sdf, t_nw, t_dr, t_drf;
  int t_half, t_halff, t_bypf, t_vcor, t_iddqf, t_done;
  logic p_en, p_sd, p_dr, p_half, p_vco, p_iddq, p_done;
  logic [7:0] p_n;
  always @(negedge clk) begin
    if (mon_clr) begin
      n_en = 0; n_ramp = 0; n_done = 0; t_enr = 0; t_enf = 0; t_sd = 0; t_sd1 = 0;
      t_sdf = 0; t_nw = 0; t_dr = 0; t_drf = 0; t_half = 0; t_halff = 0;
      t_bypf = 0; t_vcor = 0; t_iddqf = 0; t_done = 0;
    end else if (rst_n) begin
      if (pll_en && !p_en) begin n_en++; t_enr = cyc_no; end
      if (!pll_en && p_en) t_enf = cyc_no;
      if (slowdown && !p_sd) begin n_ramp++; t_sd = cyc_no; if (t_sd1 == 0) t_sd1 = cyc_no; end
      if (!slowdown && p_sd) t_sdf = cyc_no;
      if (coef_n != p_n && slowdown) t_nw = cyc_no;
      if (dynramp_en && !p_dr) t_dr = cyc_no;
      if (!dynramp_en && p_dr) t_drf = cyc_no;
      if (half_div && !p_half) t_half = cyc_no;
      if (!half_div && p_half) t_halff = cyc_no;
      if (!sel_vco && p_vco) t_bypf = cyc_no;
      if (sel_vco && !p_vco) t_vcor = cyc_no;
      if (!iddq && p_iddq) t_iddqf = cyc_no;
      if (done) n_done++;
      if (done && !p_done) t_done = cyc_no;
    end
    p_en = pll_en; p_sd = slowdown; p_dr = dynramp_en; p_half = half_div;
    p_vco = sel_vco; p_iddq = iddq; p_done = done; p_n = coef_n;
  end

  int checks = 0, fails = 0;
  task automatic ceq(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic run(input logic [7:0] m, input logic [5:0] pl, input logic [7:0] n,
                     input logic [7:0] nn, input logic [7:0] nc, input logic sl,
                     input logic off, input logic poke);
    mon_clr = 1'b1;
    @(negedge clk); #1;
    mon_clr = 1'b0;
    new_m = m; new_pl = pl; tgt_n = n; nlo_new = nn; nlo_cur = nc; slide_en = sl;
    if (off) req_off = 1'b1; else req_on = 1'b1;
    @(negedge clk); #1;
    req_on = 1'b0; req_off = 1'b0;
    for (int i = 0; i < 20000; i++) begin
      if (done) break;
      if (poke && i == 3) req_off = 1'b1;
      if (poke && i == 4) req_off = 1'b0;
      @(negedge clk); #1;
    end
    ceq("R11 done reached", int'(done), 1);
  endtask

  // m, pl, n, nlo_new, nlo_cur, slide, pll_en rises, ramps
  localparam int NV = 6;
  localparam logic [42:0] VEC [NV] = '{
    {8'd1, 6'd3, 8'd40, 8'd30, 8'd0,  1'b1, 2'd1, 2'd1},
    {8'd1, 6'd3, 8'd60, 8'd30, 8'd30, 1'b1, 2'd0, 2'd1},
    {8'd1, 6'd3, 8'd60, 8'd30, 8'd30, 1'b1, 2'd0, 2'd0},
    {8'd2, 6'd2, 8'd90, 8'd60, 8'd30, 1'b1, 2'd1, 2'd2},
    {8'd2, 6'd2, 8'd70, 8'd60, 8'd60, 1'b0, 2'd1, 2'd0},
    {8'd3, 6'd1, 8'd50, 8'd45, 8'd60, 1'b1, 2'd1, 2'd2}
  };

  initial begin
    #500000;
    fails++;
    $display("FAIL R11 watchdog: actual 1 expected 0");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    #1;
    ceq("R1 busy", int'(busy), 0);
    ceq("R1 iddq", int'(iddq), 1);
    ceq("R1 pll_en", int'(pll_en), 0);
    ceq("R1 sel_vco", int'(sel_vco), 0);
    ceq("R1 half_div", int'(half_div), 0);
    ceq("R1 slowdown/dynramp", int'({slowdown, dynramp_en}), 0);
    ceq("R1 done", int'(done), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    for (int v = 0; v < NV; v++) begin
      run(VEC[v][42:35], VEC[v][34:29], VEC[v][28:21], VEC[v][20:13], VEC[v][12:5],
          VEC[v][4], 1'b0, 1'b0);
      ceq("R6 coef_m", int'(coef_m), int'(VEC[v][42:35]));
      ceq("R6 coef_pl", int'(coef_pl), int'(VEC[v][34:29]));
      ceq("R8 final coef_n", int'(coef_n), int'(VEC[v][28:21]));
      ceq("R7 no fail", int'(fail), 0);
      ceq("R8 running on vco 1:1", int'({sel_vco, half_div, pll_en, iddq, lckdet_en}), 5'b10101);
      ceq("R2 pll_en rises", n_en, int'(VEC[v][3:2]));
      ceq("R3 ramp count", n_ramp, int'(VEC[v][1:0]));
      if (v == 0) ceq("R6 iddq wait", int'(t_enr - t_iddqf >= 2*T), 1);
      if (v == 1) begin
        ceq("R3 step_a", int'(step_a), 8'h2B);
        ceq("R3 step_b", int'(step_b), 8'h0B);
        ceq("R3 N write delay", t_nw - t_sd, T);
        ceq("R3 dynramp delay", t_dr - t_nw, T);
      end
      if (v == 3) begin
        ceq("R5 ramp down before halving", int'(t_sd1 < t_half), 1);
        ceq("R5 bypass delay", t_bypf - t_half, 2*T);
        ceq("R8 divider restore delay", t_halff - t_vcor, 2*T);
      end
      @(negedge clk);
    end

    // ramp timeout, retried without slide
    ramp_hang = 1'b1;
    run(8'd3, 6'd1, 8'd55, 8'd45, 8'd45, 1'b1, 1'b0, 1'b0);
    ramp_hang = 1'b0;
    ceq("R4 dynramp held for all polls", t_drf - t_dr, RP*T);
    ceq("R4 slowdown cleared with dynramp", t_sdf, t_drf);
    ceq("R9 retry relocked", n_en, 1);
    ceq("R9 retry wrote target N", int'(coef_n), 55);
    ceq("R9 retry no fail", int'(fail), 0);
    @(negedge clk);

    // request during busy ignored
    run(8'd3, 6'd1, 8'd58, 8'd45, 8'd45, 1'b1, 1'b0, 1'b1);
    repeat (10) @(negedge clk);
    #1;
    ceq("R11 busy released", int'(busy), 0);
    ceq("R11 off request ignored", int'(pll_en), 1);
    ceq("R11 single done cycle", n_done, 1);
    ceq("R2 N-only result", int'(coef_n), 58);

    // lock failure
    lock_hang = 1'b1;
    run(8'd2, 6'd1, 8'd80, 8'd60, 8'd45, 1'b0, 1'b0, 1'b0);
    lock_hang = 1'b0;
    ceq("R7 fail flagged", int'(fail), 1);
    ceq("R7 left in bypass", int'(sel_vco), 0);
    ceq("R7 poll window", t_done - t_enr, 2*LP*T);
    @(negedge clk);

    run(8'd2, 6'd1, 8'd80, 8'd60, 8'd45, 1'b0, 1'b0, 1'b0);
    ceq("R7 recovery no fail", int'(fail), 0);
    ceq("R8 recovery on vco", int'(sel_vco), 1);
    @(negedge clk);

    // disable
    run(8'd0, 6'd0, 8'd0, 8'd0, 8'd40, 1'b1, 1'b1, 1'b0);
    ceq("R10 ramped to nlo", int'(coef_n), 40);
    ceq("R10 one ramp", n_ramp, 1);
    ceq("R10 bypass then off", int'(t_bypf < t_enf && t_bypf != 0), 1);
    ceq("R10 pll off", int'({pll_en, sel_vco}), 0);
    ceq("R10 no fail", int'(fail), 0);
    @(negedge clk);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule